// File: doc/BRIEF.md
# Short-Circuit Desaturation Guard for a Power Switch Gate Driver

This block sits between a PWM command coming from the system controller and the analog gate driver of a power switch. It passes the command on as a gate-on enable. It watches the output of an external desaturation comparator, which goes high when the switch's collector-emitter voltage is too high. A short circuit is recognised only when the gate is commanded on and the comparator reads high at the same time.

After every turn-on, the comparator is masked for a blanking window. This lets the collector voltage fall during a normal turn-on without being taken for a fault. The two-flop synchronization delay on the inputs is counted as part of that window.

When a short circuit is recognised, the block turns the gate off at once through the slow, soft-shutdown path and enters a timed lockout. During the lockout it pulls an active-low fault flag low. The gate stays off for the whole lockout, whatever the command does. The block arms again only after the lockout has run out and the command has also returned to off.

Window lengths are cycle-count parameters. At 100 MHz, the defaults give a 3 µs blanking window and a 1.5 ms lockout. The lockout must be at least as long as the minimum fault-flag width the system controller expects.

Top module: `desat_guard`

## Requirements
- R1: After a synchronous reset, the outputs are gate_en_o=0, soft_off_o=0 and fault_n_o=1, and state_o is 0 (idle).
- R2: With the comparator low, gate_en_o rises in the third clock cycle after cmd_on_i rises. It falls in the third clock cycle after cmd_on_i falls. soft_off_o stays 0 and fault_n_o stays 1 throughout.
- R3: A comparator pulse that ends inside the blanking window does not turn the gate off. state_o reaches 2 (on) and gate_en_o stays high.
- R4: If the comparator is high from before a turn-on, gate_en_o stays high for exactly BLANK_CYC-1 clock cycles and then drops into lockout.
- R5: A comparator rise while the gate is on turns gate_en_o off in the third clock cycle. In that same cycle soft_off_o goes to 1 and fault_n_o goes to 0.
- R6: If the command is already off, fault_n_o stays low for exactly LOCK_CYC clock cycles after a detection.
- R7: If the command is still on when the lockout expires, gate_en_o stays 0 and fault_n_o stays low. Once the command goes off, soft_off_o and fault_n_o are released in the same cycle and state_o returns to 0.
- R8: If the command drops during blanking, the block returns to idle with the gate off. The next turn-on blanks for a full BLANK_CYC again.
- R9: state_o encodes idle as 0, blanking as 1, on as 2 and lockout as 3.
- R10: A comparator high level while the command is off has no effect: gate_en_o=0, fault_n_o=1, state_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on_i | input | 1 | PWM gate command, 1 = on (asynchronous) |
| desat_i | input | 1 | Desaturation comparator, 1 = collector voltage above trip level (asynchronous) |
| gate_en_o | output | 1 | Gate-on enable to the output stage |
| soft_off_o | output | 1 | Selects the slow turn-off path; high for the whole lockout |
| fault_n_o | output | 1 | Active-low fault flag to the system controller |
| state_o | output | 2 | Present state: 0 idle, 1 blanking, 2 on, 3 lockout |

## Verification
If the blanking counter were wrong, the on-time of the gate with the comparator held high would differ from BLANK_CYC-1 cycles, and this shows up within one switching period. A wrong lockout counter or a wrong re-arm condition stretches or shortens the low time of fault_n_o. It can also let gate_en_o rise while the command is still held on. Both are visible within LOCK_CYC cycles of the detection. A wrong state encoding or a wrong transition shows on state_o in the cycle the transition occurs, so the directed scenarios compare state_o right after each edge of interest.

// File: rtl/desat_pkg.sv
package desat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_ON    = 2'd2,
    ST_LOCK  = 2'd3
  } guard_state_e;
endpackage

// File: rtl/desat_sync2.sv
module desat_sync2 #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/desat_timer.sv
module desat_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i)          cnt_q <= '0;
    else if (en_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R8
  clr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));

  // R6
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o || cnt_q == '0));
endmodule

// File: rtl/desat_guard.sv
module desat_guard
  import desat_pkg::*;
#(
  parameter int BLANK_CYC = 300,
  parameter int LOCK_CYC  = 150000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_on_i,
  input  logic       desat_i,
  output logic       gate_en_o,
  output logic       soft_off_o,
  output logic       fault_n_o,
  output logic [1:0] state_o
);
  localparam int SYNC_STAGES = 2;
  localparam int BLANK_CNT   = BLANK_CYC - SYNC_STAGES;

  logic [1:0] raw_in, sync_in;
  logic cmd_s, desat_s;
  logic blank_done, lock_done;
  guard_state_e state_q, state_d;

  assign raw_in = {desat_i, cmd_on_i};

  desat_sync2 #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_in)
  );

  assign cmd_s   = sync_in[0];
  assign desat_s = sync_in[1];

  desat_timer #(.LIMIT(BLANK_CNT)) u_blank (
    .clk(clk), .rst(rst),
    .clr_i(state_q != ST_BLANK || !cmd_s),
    .en_i(state_q == ST_BLANK),
    .done_o(blank_done)
  );

  desat_timer #(.LIMIT(LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst),
    .clr_i(state_q != ST_LOCK),
    .en_i(state_q == ST_LOCK),
    .done_o(lock_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_s) state_d = ST_BLANK;
      ST_BLANK: begin
        if (!cmd_s)          state_d = ST_IDLE;
        else if (blank_done) state_d = ST_ON;
      end
      ST_ON: begin
        if (!cmd_s)       state_d = ST_IDLE;
        else if (desat_s) state_d = ST_LOCK;
      end
      ST_LOCK:  if (lock_done && !cmd_s) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      gate_en_o  <= 1'b0;
      soft_off_o <= 1'b0;
      fault_n_o  <= 1'b1;
    end else begin
      state_q    <= state_d;
      gate_en_o  <= (state_d == ST_BLANK) || (state_d == ST_ON);
      soft_off_o <= (state_d == ST_LOCK);
      fault_n_o  <= (state_d != ST_LOCK);
    end
  end

  assign state_o = state_q;

  // R5
  gate_soft_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_en_o && soft_off_o));

  // R7
  fault_soft_pair_chk: assert property (@(posedge clk) disable iff (rst)
    soft_off_o == !fault_n_o);

  // R2
  gate_rise_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en_o) |-> ($past(state_q) == ST_IDLE));

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK && cmd_s) |=> (state_q == ST_LOCK && !gate_en_o));

  // R5
  trip_to_soft_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ON && cmd_s && desat_s) |=> (soft_off_o && !fault_n_o));

  // R3
  blank_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BLANK && cmd_s) |=> gate_en_o);
endmodule

// File: tb/sim_desat_guard.sv
module sim_desat_guard;
  localparam int BLANK_CYC = 10;
  localparam int LOCK_CYC  = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd = 1'b0;
  logic desat = 1'b0;
  logic gate_en, soft_off, fault_n;
  logic [1:0] st;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  desat_guard #(.BLANK_CYC(BLANK_CYC), .LOCK_CYC(LOCK_CYC)) u0 (
    .clk(clk), .rst(rst), .cmd_on_i(cmd), .desat_i(desat),
    .gate_en_o(gate_en), .soft_off_o(soft_off), .fault_n_o(fault_n),
    .state_o(st)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; cmd = 1'b0; desat = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk(gate_en == 1'b0, "R1 gate", gate_en, 0);
    chk(soft_off == 1'b0, "R1 soft", soft_off, 0);
    chk(fault_n == 1'b1, "R1 fault_n", fault_n, 1);
    chk(st == 2'd0, "R1 state", st, 0);
  endtask

  task automatic t_normal();
    cmd = 1'b1;
    cyc(2);
    chk(gate_en == 1'b0, "R2 gate before 3rd cycle", gate_en, 0);
    cyc(1);
    chk(gate_en == 1'b1, "R2 gate on 3rd cycle", gate_en, 1);
    chk(st == 2'd1, "R9 blanking code", st, 1);
    cyc(BLANK_CYC + 2);
    chk(st == 2'd2, "R9 on code", st, 2);
    chk(soft_off == 1'b0 && fault_n == 1'b1, "R2 no fault", fault_n, 1);
    cmd = 1'b0;
    cyc(2);
    chk(gate_en == 1'b1, "R2 gate before off", gate_en, 1);
    cyc(1);
    chk(gate_en == 1'b0, "R2 gate off 3rd cycle", gate_en, 0);
    chk(soft_off == 1'b0, "R2 hard off", soft_off, 0);
    chk(st == 2'd0, "R9 idle code", st, 0);
    cyc(3);
  endtask

  task automatic t_idle_desat();
    desat = 1'b1;
    cyc(6);
    chk(gate_en == 1'b0, "R10 gate", gate_en, 0);
    chk(fault_n == 1'b1, "R10 fault_n", fault_n, 1);
    chk(st == 2'd0, "R10 state", st, 0);
    desat = 1'b0;
    cyc(3);
  endtask

  task automatic t_blank_ignore();
    cmd = 1'b1;
    cyc(3);
    desat = 1'b1;
    cyc(3);
    desat = 1'b0;
    cyc(BLANK_CYC + 4);
    chk(gate_en == 1'b1, "R3 gate kept", gate_en, 1);
    chk(st == 2'd2, "R3 reached on", st, 2);
    chk(fault_n == 1'b1, "R3 no fault", fault_n, 1);
    cmd = 1'b0;
    cyc(5);
  endtask

  task automatic t_fault_on();
    cmd = 1'b1;
    cyc(BLANK_CYC + 5);
    desat = 1'b1;
    cyc(2);
    chk(gate_en == 1'b1, "R5 gate before trip", gate_en, 1);
    cyc(1);
    chk(gate_en == 1'b0, "R5 gate off", gate_en, 0);
    chk(soft_off == 1'b1, "R5 soft", soft_off, 1);
    chk(fault_n == 1'b0, "R5 fault_n", fault_n, 0);
    chk(st == 2'd3, "R9 lock code", st, 3);
    cmd = 1'b0; desat = 1'b0;
    cyc(LOCK_CYC + 4);
  endtask

  task automatic t_short_count();
    int on_cnt = 0;
    int lo_cnt = 0;
    desat = 1'b1;
    cmd = 1'b1;
    cyc(1);
    for (int i = 0; i < 200; i++) begin
      if (gate_en) on_cnt++;
      else if (on_cnt > 0) break;
      cyc(1);
    end
    chk(on_cnt == BLANK_CYC - 1, "R4 on cycles", on_cnt, BLANK_CYC - 1);
    cmd = 1'b0; desat = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (!fault_n) lo_cnt++;
      else break;
      cyc(1);
    end
    chk(lo_cnt == LOCK_CYC, "R6 fault low cycles", lo_cnt, LOCK_CYC);
    chk(st == 2'd0, "R6 back idle", st, 0);
    cyc(3);
  endtask

  task automatic t_lock_hold();
    desat = 1'b1;
    cmd = 1'b1;
    cyc(BLANK_CYC + 4);
    desat = 1'b0;
    cyc(LOCK_CYC + 10);
    chk(gate_en == 1'b0, "R7 gate held off", gate_en, 0);
    chk(fault_n == 1'b0, "R7 fault held", fault_n, 0);
    chk(st == 2'd3, "R7 still locked", st, 3);
    cmd = 1'b0;
    cyc(2);
    chk(fault_n == 1'b0, "R7 fault before release", fault_n, 0);
    cyc(1);
    chk(fault_n == 1'b1 && soft_off == 1'b0, "R7 released together", soft_off, 0);
    chk(st == 2'd0, "R7 idle", st, 0);
    cyc(3);
  endtask

  task automatic t_restart();
    int on_cnt = 0;
    cmd = 1'b1;
    cyc(6);
    cmd = 1'b0;
    cyc(3);
    chk(st == 2'd0, "R8 idle after drop", st, 0);
    chk(gate_en == 1'b0, "R8 gate off", gate_en, 0);
    desat = 1'b1;
    cmd = 1'b1;
    cyc(1);
    for (int i = 0; i < 200; i++) begin
      if (gate_en) on_cnt++;
      else if (on_cnt > 0) break;
      cyc(1);
    end
    chk(on_cnt == BLANK_CYC - 1, "R8 full blank after restart", on_cnt, BLANK_CYC - 1);
    cmd = 1'b0; desat = 1'b0;
    cyc(LOCK_CYC + 4);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(1);
    t_reset();
    t_normal();
    t_idle_desat();
    t_blank_ignore();
    t_fault_on();
    t_short_count();
    t_lock_hold();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule